// File: doc/BRIEF.md
# In-Flight Transaction Tracking Table

This block holds the transactions a second-level cache controller has in flight, one entry per line address. An entry records a transient state, a dirty flag, a set of requesters that wait for the line's data, and a count of atomic operations that were forwarded downstream but have not yet been answered. The controller issues one command per cycle against an address: allocate, add a requester, increment or decrement the atomic count, update state and dirty, or free. A separate lookup port compares any address against all entries in the same cycle and returns the entry's fields.

When a decrement brings the atomic count to zero, the table posts the address into an in-order trigger queue rather than freeing the entry at once. The controller drains the queue at its own pace. When it pops a trigger, the count is checked again at that moment. If it is still zero, the entry is freed. If another atomic has arrived in the meantime, the trigger is dropped and the entry stays. The table also pulses a forward-read indication when a read requester lands on an entry whose requester set then holds exactly that one bit. The controller uses it to send a single downstream read for any number of merged readers.

Top module: `txn_track_table`

## Requirements
- R1: After reset no entry matches any address, `full_o`, `trig_valid_o` and `fwd_rd_o` are low.
- R2: A command with `cmd_op_i`=0 (allocate) for an address not in the table, with a free slot, creates one entry. It has an atomic count of 0, the state (`cmd_state_i`: 0 invalid, 1 wait data, 2 wait ack, 3 wait atomic) and dirty flag from the command, and a requester set that is either empty or holds only bit `cmd_rid_i`.
- R3: Allocating an address already present creates no second entry. It only merges the requester into the existing set and leaves count, state and dirty as they were.
- R4: The requester bit (1 << `cmd_rid_i`) joins the set only when `cmd_kind_i` is 0 (read) or 2 (atomic). With kind 1 (write), the set is unchanged, both for allocate and for add-requester (`cmd_op_i`=1).
- R5: One cycle after an allocate or add-requester of kind read, `fwd_rd_o` is high with `fwd_addr_o` set to the command address, exactly when the set then holds one bit. Otherwise `fwd_rd_o` stays low.
- R6: `cmd_op_i`=2 raises the entry's atomic count by one and `cmd_op_i`=3 lowers it by one. A decrement at count 0 leaves the count at 0.
- R7: A decrement that leaves the count at 0 pushes the address into the trigger queue. Triggers leave the queue in push order on `trig_addr_o` while `trig_valid_o` is high.
- R8: Popping a trigger (`trig_pop_i`) frees the matching entry if its count is 0 at that moment, after which a lookup misses and reads state 0. If the count is not 0, or no entry matches, the trigger is discarded and the table is unchanged.
- R9: A pop in a cycle with `cmd_valid_i` high is ignored, and the head trigger stays.
- R10: `cmd_op_i`=4 frees the entry. A later allocate of the same address starts with an empty set and a count of 0.
- R11: `full_o` is high when every slot is in use. An allocate of a new address while full changes nothing.
- R12: `cmd_op_i`=5 overwrites the entry's state and dirty flag from the command.
- R13: No address ever matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | 0 alloc, 1 add requester, 2 inc, 3 dec, 4 free, 5 update |
| cmd_addr_i | input | ADDR_W | Line address of the command |
| cmd_rid_i | input | RID_W | Requester number, selects a bit of the set |
| cmd_kind_i | input | 2 | 0 read, 1 write, 2 atomic |
| cmd_state_i | input | 2 | State written on alloc or update |
| cmd_dirty_i | input | 1 | Dirty flag written on alloc or update |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_hit_o | output | 1 | Lookup matched an entry |
| lk_idx_o | output | IDX_W | Slot of the match |
| lk_state_o | output | 2 | State of the match, 0 on miss |
| lk_dest_o | output | N_REQ | Requester set of the match |
| lk_dirty_o | output | 1 | Dirty flag of the match |
| lk_cnt_o | output | CNT_W | Atomic count of the match |
| full_o | output | 1 | No free slot |
| fwd_rd_o | output | 1 | Issue one downstream read |
| fwd_addr_o | output | ADDR_W | Address for that read |
| trig_valid_o | output | 1 | Trigger queue not empty |
| trig_addr_o | output | ADDR_W | Address at the queue head |
| trig_pop_i | input | 1 | Handle and remove the head trigger |

## Verification
The bench lets a new atomic arrive between the drain to zero and the pop. A table that frees on the push, or that does not recheck at the pop, loses a live entry. It queues two triggers for one address. A design that does not discard a stale trigger on a miss would free or corrupt something. It also drives a pop in the same cycle as a command; a design that does not block that pop drops the trigger early. Merging a second reader, adding a writer, and reallocating after a free expose a table that duplicates entries, forwards a second read, counts writers in the set, or leaks an old set or count into a new entry. The bench also fills every slot and then offers one more address.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    OP_ALLOC = 3'd0,
    OP_ADD   = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_FREE  = 3'd4,
    OP_UPD   = 3'd5
  } txn_op_e;

  typedef enum logic [1:0] {
    K_READ   = 2'd0,
    K_WRITE  = 2'd1,
    K_ATOMIC = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    TS_INV       = 2'd0,
    TS_WAIT_DATA = 2'd1,
    TS_WAIT_ACK  = 2'd2,
    TS_WAIT_ATOM = 2'd3
  } txn_state_e;
endpackage

// File: rtl/txn_cam.sv
module txn_cam #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int IW = 3
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  input  logic [AW-1:0]        key_i,
  output logic [N-1:0]         match_o,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (addr_i[g] == key_i);
  end

  assign hit_o = |match_o;

  // match is one-hot, so an OR-style encode is enough
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/txn_pick_free.sv
module txn_pick_free #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  valid_i,
  output logic          any_free_o,
  output logic [IW-1:0] idx_o
);
  assign any_free_o = ~&valid_i;

  // lowest free slot wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/txn_slot.sv
module txn_slot #(
  parameter int AW = 32,
  parameter int RW = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          merge_i,
  input  logic [RW-1:0] mask_i,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          free_i,
  input  logic          upd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    state_i,
  input  logic          dirty_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    state_o,
  output logic [RW-1:0] dest_o,
  output logic          dirty_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      state_o <= '0;
      dest_o  <= '0;
      dirty_o <= 1'b0;
      cnt_o   <= '0;
    end else if (free_i) begin
      valid_o <= 1'b0;
      state_o <= '0;
      dest_o  <= '0;
      dirty_o <= 1'b0;
      cnt_o   <= '0;
    end else if (alloc_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      state_o <= state_i;
      dest_o  <= mask_i;
      dirty_o <= dirty_i;
      cnt_o   <= '0;
    end else begin
      if (merge_i) dest_o <= dest_o | mask_i;
      if (inc_i && cnt_o != '1) cnt_o <= cnt_o + CW'(1);
      if (dec_i && cnt_o != '0) cnt_o <= cnt_o - CW'(1);
      if (upd_i) begin
        state_o <= state_i;
        dirty_o <= dirty_i;
      end
    end
  end
endmodule

// File: rtl/txn_trig_fifo.sv
module txn_trig_fifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [AW-1:0] head_o,
  output logic [LW-1:0] level_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][AW-1:0] mem;
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop  = pop_i && (level_o != '0);
  assign do_push = push_i && (level_o != LW'(DEPTH));
  assign valid_o = (level_o != '0);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      level_o <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      level_o <= level_o + LW'(1);
      else if (do_pop && !do_push) level_o <= level_o - LW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= addr_i;
  end
endmodule

// File: rtl/txn_track_table.sv
module txn_track_table
  import txn_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 32,
  parameter int N_REQ     = 8,
  parameter int CNT_W     = 4,
  parameter int TQ_DEPTH  = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int RID_W    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [RID_W-1:0]  cmd_rid_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [1:0]        cmd_state_i,
  input  logic              cmd_dirty_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [1:0]        lk_state_o,
  output logic [N_REQ-1:0]  lk_dest_o,
  output logic              lk_dirty_o,
  output logic [CNT_W-1:0]  lk_cnt_o,
  output logic              full_o,
  output logic              fwd_rd_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic              trig_valid_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  input  logic              trig_pop_i
);
  localparam int LVL_W = $clog2(TQ_DEPTH + 1);

  logic [N_ENTRIES-1:0]             slot_valid;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] slot_addr;
  logic [N_ENTRIES-1:0][1:0]        slot_state;
  logic [N_ENTRIES-1:0][N_REQ-1:0]  slot_dest;
  logic [N_ENTRIES-1:0]             slot_dirty;
  logic [N_ENTRIES-1:0][CNT_W-1:0]  slot_cnt;

  logic [N_ENTRIES-1:0] cmd_match, lk_match, tq_match;
  logic                 cmd_hit, tq_hit;
  logic [IDX_W-1:0]     cmd_idx, tq_idx, free_idx;
  logic                 any_free;
  logic [LVL_W-1:0]     tq_level;

  txn_cam #(.N(N_ENTRIES), .AW(ADDR_W), .IW(IDX_W)) u_cmd_cam (
    .valid_i(slot_valid), .addr_i(slot_addr), .key_i(cmd_addr_i),
    .match_o(cmd_match), .hit_o(cmd_hit), .idx_o(cmd_idx)
  );

  txn_cam #(.N(N_ENTRIES), .AW(ADDR_W), .IW(IDX_W)) u_lk_cam (
    .valid_i(slot_valid), .addr_i(slot_addr), .key_i(lk_addr_i),
    .match_o(lk_match), .hit_o(lk_hit_o), .idx_o(lk_idx_o)
  );

  txn_cam #(.N(N_ENTRIES), .AW(ADDR_W), .IW(IDX_W)) u_tq_cam (
    .valid_i(slot_valid), .addr_i(slot_addr), .key_i(trig_addr_o),
    .match_o(tq_match), .hit_o(tq_hit), .idx_o(tq_idx)
  );

  txn_pick_free #(.N(N_ENTRIES), .IW(IDX_W)) u_pick (
    .valid_i(slot_valid), .any_free_o(any_free), .idx_o(free_idx)
  );

  assign full_o = !any_free;

  // command decode
  logic             is_alloc, joins_dest;
  logic             do_alloc_new, do_merge, do_inc, do_dec, do_free, do_upd;
  logic [N_REQ-1:0] rid_mask, new_dest, cmd_dest;
  logic [CNT_W-1:0] cmd_cnt, tq_cnt;
  logic             pop_ok, trig_free, tq_push, fwd_fire;

  assign is_alloc     = cmd_valid_i && (cmd_op_i == OP_ALLOC);
  assign joins_dest   = (cmd_kind_i == K_READ) || (cmd_kind_i == K_ATOMIC);
  assign rid_mask     = joins_dest ? (N_REQ'(1) << cmd_rid_i) : '0;
  assign do_alloc_new = is_alloc && !cmd_hit && any_free;
  assign do_merge     = cmd_valid_i && cmd_hit &&
                        ((cmd_op_i == OP_ALLOC) || (cmd_op_i == OP_ADD));
  assign do_inc       = cmd_valid_i && cmd_hit && (cmd_op_i == OP_INC);
  assign do_dec       = cmd_valid_i && cmd_hit && (cmd_op_i == OP_DEC);
  assign do_free      = cmd_valid_i && cmd_hit && (cmd_op_i == OP_FREE);
  assign do_upd       = cmd_valid_i && cmd_hit && (cmd_op_i == OP_UPD);

  assign cmd_cnt  = slot_cnt[cmd_idx];
  assign cmd_dest = slot_dest[cmd_idx];
  assign tq_cnt   = slot_cnt[tq_idx];

  // a command owns the cycle; pops wait for an idle one
  assign pop_ok    = trig_pop_i && !cmd_valid_i && trig_valid_o;
  assign trig_free = pop_ok && tq_hit && (tq_cnt == '0);
  assign tq_push   = do_dec && (cmd_cnt == CNT_W'(1));

  assign new_dest = do_alloc_new ? rid_mask : (cmd_dest | rid_mask);
  assign fwd_fire = (do_alloc_new || do_merge) && (cmd_kind_i == K_READ) &&
                    ($countones(new_dest) == 1);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    txn_slot #(.AW(ADDR_W), .RW(N_REQ), .CW(CNT_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (do_alloc_new && (free_idx == IDX_W'(g))),
      .merge_i (do_merge && cmd_match[g]),
      .mask_i  (rid_mask),
      .inc_i   (do_inc && cmd_match[g]),
      .dec_i   (do_dec && cmd_match[g]),
      .free_i  ((do_free && cmd_match[g]) || (trig_free && tq_match[g])),
      .upd_i   (do_upd && cmd_match[g]),
      .addr_i  (cmd_addr_i),
      .state_i (cmd_state_i),
      .dirty_i (cmd_dirty_i),
      .valid_o (slot_valid[g]),
      .addr_o  (slot_addr[g]),
      .state_o (slot_state[g]),
      .dest_o  (slot_dest[g]),
      .dirty_o (slot_dirty[g]),
      .cnt_o   (slot_cnt[g])
    );
  end

  txn_trig_fifo #(.AW(ADDR_W), .DEPTH(TQ_DEPTH), .LW(LVL_W)) u_tq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tq_push),
    .addr_i  (cmd_addr_i),
    .pop_i   (pop_ok),
    .valid_o (trig_valid_o),
    .head_o  (trig_addr_o),
    .level_o (tq_level)
  );

  assign lk_state_o = lk_hit_o ? slot_state[lk_idx_o] : TS_INV;
  assign lk_dest_o  = lk_hit_o ? slot_dest[lk_idx_o]  : '0;
  assign lk_dirty_o = lk_hit_o && slot_dirty[lk_idx_o];
  assign lk_cnt_o   = lk_hit_o ? slot_cnt[lk_idx_o]   : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_rd_o   <= 1'b0;
      fwd_addr_o <= '0;
    end else begin
      fwd_rd_o <= fwd_fire;
      if (fwd_fire) fwd_addr_o <= cmd_addr_i;
    end
  end
endmodule

// File: rtl/txn_track_chk.sv
module txn_track_chk #(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter int LW = 3,
  parameter int TD = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic [1:0]    cmd_kind_i,
  input logic          trig_pop_i,
  input logic          fwd_rd_o,
  input logic [N-1:0]  slot_valid,
  input logic [N-1:0]  cmd_match,
  input logic          cmd_hit,
  input logic [CW-1:0] cmd_cnt,
  input logic          any_free,
  input logic [LW-1:0] tq_level
);
  // R13
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_match));

  // R2
  alloc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd0 && !cmd_hit && any_free)
    |=> ($countones(slot_valid) == $past($countones(slot_valid)) + 1));

  // R3
  merge_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd0 && cmd_hit) |=> $stable(slot_valid));

  // R11
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd0 && !cmd_hit && !any_free) |=> $stable(slot_valid));

  // R7
  trig_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd3 && cmd_hit && cmd_cnt == CW'(1) &&
     int'(tq_level) < TD)
    |=> (int'(tq_level) == int'($past(tq_level)) + 1));

  // R9
  pop_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && trig_pop_i && cmd_op_i != 3'd3) |=> $stable(tq_level));

  // R5
  fwd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rd_o |-> $past(cmd_valid_i && cmd_kind_i == 2'd0));
endmodule

bind txn_track_table txn_track_chk #(
  .N(N_ENTRIES), .CW(CNT_W), .LW(LVL_W), .TD(TQ_DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_kind_i  (cmd_kind_i),
  .trig_pop_i  (trig_pop_i),
  .fwd_rd_o    (fwd_rd_o),
  .slot_valid  (slot_valid),
  .cmd_match   (cmd_match),
  .cmd_hit     (cmd_hit),
  .cmd_cnt     (cmd_cnt),
  .any_free    (any_free),
  .tq_level    (tq_level)
);

// File: tb/tb_txn_track_table.sv
module tb_txn_track_table;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  localparam int F_HIT = 0, F_STATE = 1, F_DEST = 2, F_DIRTY = 3, F_CNT = 4;
  localparam int F_FULL = 5, F_TVAL = 6, F_TADDR = 7, F_FWD = 8, F_FADDR = 9;

  typedef struct {
    string       req;
    int          fld;
    logic [31:0] exp;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = '0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [2:0]    cmd_rid_i = '0;
  logic [1:0]    cmd_kind_i = '0;
  logic [1:0]    cmd_state_i = '0;
  logic          cmd_dirty_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0;
  logic          lk_hit_o;
  logic [2:0]    lk_idx_o;
  logic [1:0]    lk_state_o;
  logic [7:0]    lk_dest_o;
  logic          lk_dirty_o;
  logic [3:0]    lk_cnt_o;
  logic          full_o, fwd_rd_o, trig_valid_o;
  logic [AW-1:0] fwd_addr_o, trig_addr_o;
  logic          trig_pop_i = 1'b0;

  txn_track_table dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  exp_t exp_q[$];
  event flush_ev;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // monitor: pops expected items and compares against live outputs
  initial begin
    forever begin
      @(flush_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        case (it.fld)
          F_HIT:   act = 32'(lk_hit_o);
          F_STATE: act = 32'(lk_state_o);
          F_DEST:  act = 32'(lk_dest_o);
          F_DIRTY: act = 32'(lk_dirty_o);
          F_CNT:   act = 32'(lk_cnt_o);
          F_FULL:  act = 32'(full_o);
          F_TVAL:  act = 32'(trig_valid_o);
          F_TADDR: act = trig_addr_o;
          F_FWD:   act = 32'(fwd_rd_o);
          default: act = fwd_addr_o;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s field=%0d actual=%h expected=%h", it.req, it.fld, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input string req, input int fld, input logic [31:0] v);
    exp_t it;
    it.req = req; it.fld = fld; it.exp = v;
    exp_q.push_back(it);
  endtask

  task automatic flush();
    -> flush_ev;
    #1;
  endtask

  task automatic probe(input logic [AW-1:0] a);
    lk_addr_i = a;
    #1;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [2:0] rid,
                     input logic [1:0] kind, input logic [1:0] st, input logic dirty,
                     input logic with_pop);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_rid_i = rid;
    cmd_kind_i = kind; cmd_state_i = st; cmd_dirty_i = dirty; trig_pop_i = with_pop;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; trig_pop_i = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk_i);
    trig_pop_i = 1'b1;
    @(negedge clk_i);
    trig_pop_i = 1'b0;
  endtask

  localparam logic [AW-1:0] A = 32'h1000, B = 32'h2000, C = 32'h3000, X = 32'h9000;

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    probe(A);
    expect_v("R1 hit", F_HIT, 0); expect_v("R1 full", F_FULL, 0);
    expect_v("R1 tval", F_TVAL, 0); expect_v("R1 fwd", F_FWD, 0);
    flush();

    // R2 / R5: new read entry
    cmd(3'd0, A, 3'd3, 2'd0, 2'd1, 1'b0, 1'b0);
    expect_v("R5 fwd first reader", F_FWD, 1); expect_v("R5 fwd addr", F_FADDR, A);
    flush();
    probe(A);
    expect_v("R2 hit", F_HIT, 1); expect_v("R2 dest", F_DEST, 32'h08);
    expect_v("R2 cnt", F_CNT, 0); expect_v("R2 state", F_STATE, 1);
    expect_v("R2 dirty", F_DIRTY, 0);
    flush();

    // R3: re-alloc merges
    cmd(3'd0, A, 3'd5, 2'd0, 2'd2, 1'b1, 1'b0);
    expect_v("R5 no fwd on second reader", F_FWD, 0);
    flush();
    probe(A);
    expect_v("R3 merged dest", F_DEST, 32'h28); expect_v("R3 state kept", F_STATE, 1);
    expect_v("R3 dirty kept", F_DIRTY, 0);
    flush();

    // R4: writer not added
    cmd(3'd1, A, 3'd1, 2'd1, 2'd0, 1'b0, 1'b0);
    probe(A);
    expect_v("R4 add write", F_DEST, 32'h28);
    flush();
    cmd(3'd0, B, 3'd2, 2'd1, 2'd2, 1'b1, 1'b0);
    expect_v("R5 no fwd on write alloc", F_FWD, 0);
    flush();
    probe(B);
    expect_v("R4 alloc write", F_DEST, 0); expect_v("R2 dirty set", F_DIRTY, 1);
    flush();
    cmd(3'd1, B, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0);
    expect_v("R5 fwd on first reader of existing", F_FWD, 1);
    expect_v("R5 fwd addr B", F_FADDR, B);
    flush();

    // R12
    cmd(3'd5, A, 3'd0, 2'd0, 2'd2, 1'b1, 1'b0);
    probe(A);
    expect_v("R12 state", F_STATE, 2); expect_v("R12 dirty", F_DIRTY, 1);
    flush();

    // R6 / R7 / R8 on C
    cmd(3'd0, C, 3'd4, 2'd2, 2'd3, 1'b0, 1'b0);
    expect_v("R5 no fwd atomic", F_FWD, 0);
    flush();
    probe(C);
    expect_v("R4 atomic joins", F_DEST, 32'h10);
    flush();
    cmd(3'd2, C, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    cmd(3'd2, C, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    probe(C);
    expect_v("R6 inc", F_CNT, 2);
    flush();
    cmd(3'd3, C, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    expect_v("R6 dec", F_CNT, 1); expect_v("R7 no trig at 1", F_TVAL, 0);
    flush();
    cmd(3'd3, C, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    expect_v("R7 trig", F_TVAL, 1); expect_v("R7 trig addr", F_TADDR, C);
    expect_v("R6 dec zero", F_CNT, 0);
    flush();
    cmd(3'd2, C, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    pop();
    probe(C);
    expect_v("R8 stale trig keeps", F_HIT, 1); expect_v("R8 cnt", F_CNT, 1);
    expect_v("R8 trig gone", F_TVAL, 0);
    flush();
    cmd(3'd3, C, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    pop();
    probe(C);
    expect_v("R8 freed", F_HIT, 0); expect_v("R8 state inv", F_STATE, 0);
    flush();

    // R6: dec at zero
    cmd(3'd3, B, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    probe(B);
    expect_v("R6 dec at zero", F_CNT, 0); expect_v("R6 no trig", F_TVAL, 0);
    flush();

    // R9 / R7 ordering on A
    cmd(3'd2, A, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    cmd(3'd3, A, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    cmd(3'd2, A, 3'd0, 2'd2, 2'd0, 1'b0, 1'b1);
    probe(A);
    expect_v("R9 pop blocked", F_TVAL, 1); expect_v("R9 cnt", F_CNT, 1);
    flush();
    cmd(3'd3, A, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    pop();
    probe(A);
    expect_v("R8 freed A", F_HIT, 0); expect_v("R7 second trig", F_TVAL, 1);
    expect_v("R7 second addr", F_TADDR, A);
    flush();
    pop();
    expect_v("R8 miss discarded", F_TVAL, 0);
    flush();

    // R10 / R11
    cmd(3'd4, B, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0);
    probe(B);
    expect_v("R10 free", F_HIT, 0);
    flush();
    for (int i = 0; i < 8; i++) begin
      cmd(3'd0, 32'h4000 + 32'(i * 64), 3'd0, 2'd0, 2'd1, 1'b0, 1'b0);
      if (i == 6) begin expect_v("R11 not full at 7", F_FULL, 0); flush(); end
    end
    expect_v("R11 full", F_FULL, 1);
    flush();
    cmd(3'd0, X, 3'd0, 2'd0, 2'd1, 1'b0, 1'b0);
    probe(X);
    expect_v("R11 alloc while full", F_HIT, 0); expect_v("R11 still full", F_FULL, 1);
    flush();
    cmd(3'd1, 32'h4000, 3'd6, 2'd0, 2'd0, 1'b0, 1'b0);
    cmd(3'd2, 32'h4000, 3'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    cmd(3'd4, 32'h4000, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0);
    expect_v("R11 slot freed", F_FULL, 0);
    flush();
    cmd(3'd0, 32'h4000, 3'd1, 2'd1, 2'd1, 1'b0, 1'b0);
    probe(32'h4000);
    expect_v("R10 realloc hit", F_HIT, 1); expect_v("R10 clean dest", F_DEST, 0);
    expect_v("R10 clean cnt", F_CNT, 0);
    flush();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule